// File: doc/BRIEF.md
# Programmable CRC-32 Register Engine

This block is a memory-mapped CRC calculator for 32-bit data. Software sets a generator polynomial and a seed value through registers. It then pulses a reload bit, which copies the seed into the running checksum. After that it writes data words one by one. Each write folds the whole word into the checksum within a single clock, and a read of the data location returns the checksum at any point in the stream.

Two control fields change how bits are ordered. An input field can present each word to the engine as-is, fully bit-reversed, or bit-reversed within each byte. An output flag bit-reverses the value returned on readback. With full input reversal and output reversal, and the polynomial written in its normal MSB-first form, the engine produces the reflected CRC-32 and CRC-32C results. The engine applies no final inversion, so any complement is left to the consumer.

The bus is a plain strobe interface. A write and a read are each one cycle wide. Read data is combinational from the address while the read strobe is high, and the read has no side effect.

Top module: `crc_word_engine`

## Requirements
- R1: After reset the seed register (byte offset 0x10) reads 0xFFFFFFFF, the polynomial register (offset 0x14) reads 0x04C11DB7, the control register (offset 0x08) reads 0, and the data location (offset 0x00) reads 0xFFFFFFFF.
- R2: With input mode 00 and no output reversal, each write to offset 0x00 updates the checksum C to the MSB-first polynomial division of C by the 32 data bits, bit 31 first. Writes on consecutive cycles are each folded in.
- R3: A read of offset 0x00 returns the running checksum without altering it. Repeated reads return the same value, and later data writes continue from that value.
- R4: Writing the control register with bit 0 set reloads the checksum from the seed register in the same clock. Bit 0 always reads as 0. Bits 7:5 read back as last written.
- R5: Control bits 7:6 set the input order. 00 means unchanged. 11 means the word is bit-reversed end to end. 01 and 10 mean each byte is bit-reversed in place.
- R6: Control bit 5 set makes reads of offset 0x00 return the checksum bit-reversed end to end.
- R7: With control bits 7:5 = 111 and seed 0xFFFFFFFF, polynomial 0x04C11DB7 gives the reflected CRC-32 running value (LSB-first, reversed generator 0xEDB88320). Polynomial 0x1EDC6F41 gives the reflected CRC-32C value (reversed generator 0x82F63B78).
- R8: Writing the seed or polynomial register leaves the running checksum unchanged.
- R9: Control bits 31:8 and 4:1 read 0. Reads of offsets other than 0x00, 0x08, 0x10 and 0x14 return 0, and writes to them change no register. Address bits 1:0 are ignored.
- R10: No final XOR is applied. A zero seed followed by a zero data word reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one cycle per access |
| rdEn | input | 1 | Read strobe; read data is valid in the same cycle |
| addr | input | ADDR_W (5) | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, 0 when rdEn is low |

## Verification
A corrupted checksum register is not visible until the next read of offset 0x00. From then on the corruption persists, because every later fold carries it forward until a reload. A reversal mode or polynomial that is wrong stays hidden until a data write uses it, and then shows in the first read after that write. The control readback exposes a wrong mode field at once. Stuck or leaking reload and read paths show as a changed value between two reads that have no write between them.

// File: rtl/crc_word_pkg.sv
package crc_word_pkg;

  localparam int CRC_W = 32;

  localparam int IDX_DATA = 0;
  localparam int IDX_CTRL = 2;
  localparam int IDX_SEED = 4;
  localparam int IDX_POLY = 5;

  localparam int CTL_RELOAD_BIT = 0;
  localparam int CTL_OUTREV_BIT = 5;
  localparam int CTL_INMODE_LO  = 6;

  typedef enum logic [1:0] {
    IN_PLAIN = 2'b00,
    IN_BYTEA = 2'b01,
    IN_BYTEB = 2'b10,
    IN_FULL  = 2'b11
  } inMode_t;

  typedef struct packed {
    logic loadSeed;
    logic feedWord;
  } crcStrobe_t;

  function automatic logic [CRC_W-1:0] foldWord(input logic [CRC_W-1:0] crcIn,
                                                input logic [CRC_W-1:0] dataIn,
                                                input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] acc;
    logic fb;
    acc = crcIn;
    for (int i = CRC_W - 1; i >= 0; i--) begin
      fb  = acc[CRC_W-1] ^ dataIn[i];
      acc = {acc[CRC_W-2:0], 1'b0};
      if (fb) acc = acc ^ poly;
    end
    return acc;
  endfunction

endpackage

// File: rtl/crc_word_ctrl.sv
module crc_word_ctrl
  import crc_word_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter logic [CRC_W-1:0] SEED_RESET = 32'hFFFF_FFFF,
  parameter logic [CRC_W-1:0] POLY_RESET = 32'h04C1_1DB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CRC_W-1:0]  wrData,
  input  logic [CRC_W-1:0]  crcView,
  output crcStrobe_t        strobes,
  output logic [CRC_W-1:0]  seedVal,
  output logic [CRC_W-1:0]  polyVal,
  output inMode_t           inMode,
  output logic              outRev,
  output logic [CRC_W-1:0]  rdData
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic isData, isCtrl, isSeed, isPoly;
  logic [CRC_W-1:0] ctrlView;

  assign wordIdx = addr[ADDR_W-1:2];
  assign isData  = (wordIdx == IDX_W'(IDX_DATA));
  assign isCtrl  = (wordIdx == IDX_W'(IDX_CTRL));
  assign isSeed  = (wordIdx == IDX_W'(IDX_SEED));
  assign isPoly  = (wordIdx == IDX_W'(IDX_POLY));

  assign strobes.feedWord = wrEn & isData;
  assign strobes.loadSeed = wrEn & isCtrl & wrData[CTL_RELOAD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seedVal <= SEED_RESET;
      polyVal <= POLY_RESET;
      inMode  <= IN_PLAIN;
      outRev  <= 1'b0;
    end else if (wrEn) begin
      if (isSeed) seedVal <= wrData;
      if (isPoly) polyVal <= wrData;
      if (isCtrl) begin
        inMode <= inMode_t'(wrData[CTL_INMODE_LO +: 2]);
        outRev <= wrData[CTL_OUTREV_BIT];
      end
    end
  end

  always_comb begin
    ctrlView = '0;
    ctrlView[CTL_INMODE_LO +: 2] = inMode;
    ctrlView[CTL_OUTREV_BIT]     = outRev;
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (isData)      rdData = crcView;
      else if (isCtrl) rdData = ctrlView;
      else if (isSeed) rdData = seedVal;
      else if (isPoly) rdData = polyVal;
    end
  end

endmodule

// File: rtl/crc_word_dp.sv
module crc_word_dp
  import crc_word_pkg::*;
#(
  parameter logic [CRC_W-1:0] SEED_RESET = 32'hFFFF_FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  crcStrobe_t       strobes,
  input  logic [CRC_W-1:0] wordIn,
  input  logic [CRC_W-1:0] seedVal,
  input  logic [CRC_W-1:0] polyVal,
  input  inMode_t          inMode,
  input  logic             outRev,
  output logic [CRC_W-1:0] crcView
);

  localparam int BYTES = CRC_W / 8;

  logic [CRC_W-1:0] crcQ;
  logic [CRC_W-1:0] fullRev;
  logic [CRC_W-1:0] byteRev;
  logic [CRC_W-1:0] stateRev;
  logic [CRC_W-1:0] feedVec;

  genvar gb, gi;
  generate
    for (gi = 0; gi < CRC_W; gi++) begin : g_full
      assign fullRev[gi]  = wordIn[CRC_W-1-gi];
      assign stateRev[gi] = crcQ[CRC_W-1-gi];
    end
    for (gb = 0; gb < BYTES; gb++) begin : g_lane
      for (gi = 0; gi < 8; gi++) begin : g_bit
        assign byteRev[gb*8+gi] = wordIn[gb*8+7-gi];
      end
    end
  endgenerate

  always_comb begin
    unique case (inMode)
      IN_PLAIN: feedVec = wordIn;
      IN_FULL:  feedVec = fullRev;
      default:  feedVec = byteRev;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                crcQ <= SEED_RESET;
    else if (strobes.loadSeed) crcQ <= seedVal;
    else if (strobes.feedWord) crcQ <= foldWord(crcQ, feedVec, polyVal);
  end

  assign crcView = outRev ? stateRev : crcQ;

endmodule

// File: rtl/crc_word_engine.sv
module crc_word_engine
  import crc_word_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter logic [31:0] SEED_RESET = 32'hFFFF_FFFF,
  parameter logic [31:0] POLY_RESET = 32'h04C1_1DB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData
);

  crcStrobe_t       strobes;
  logic [CRC_W-1:0] seedVal, polyVal, crcView;
  inMode_t          inMode;
  logic             outRev;

  crc_word_ctrl #(
    .ADDR_W(ADDR_W), .SEED_RESET(SEED_RESET), .POLY_RESET(POLY_RESET)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .crcView(crcView), .strobes(strobes),
    .seedVal(seedVal), .polyVal(polyVal), .inMode(inMode),
    .outRev(outRev), .rdData(rdData)
  );

  crc_word_dp #(.SEED_RESET(SEED_RESET)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .wordIn(wrData),
    .seedVal(seedVal), .polyVal(polyVal), .inMode(inMode),
    .outRev(outRev), .crcView(crcView)
  );

endmodule

// File: rtl/crc_word_engine_chk.sv
module crc_word_engine_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic [31:0]       rdData
);

  localparam int IDX_W = ADDR_W - 2;
  logic [IDX_W-1:0] idx;
  logic dataRd, ctrlRd, undefRd;
  logic seenClk;

  assign idx     = addr[ADDR_W-1:2];
  assign dataRd  = rdEn && (idx == IDX_W'(0));
  assign ctrlRd  = rdEn && (idx == IDX_W'(2));
  assign undefRd = rdEn && !(idx == IDX_W'(0) || idx == IDX_W'(2) ||
                             idx == IDX_W'(4) || idx == IDX_W'(5));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seenClk <= 1'b0;
    else        seenClk <= 1'b1;
  end

  // R4: the reload bit never reads back as set
  a_r4_reload_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlRd |-> (rdData[0] == 1'b0));

  // R9: unused control bits read as zero
  a_r9_ctrl_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlRd |-> (rdData[31:8] == 24'h0 && rdData[4:1] == 4'h0));

  // R9: holes in the map read as zero
  a_r9_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    undefRd |-> (rdData == 32'h0));

  // R3: back-to-back data reads with no write between agree
  a_r3_read_no_disturb: assert property (@(posedge clk) disable iff (!rst_n)
    (seenClk && dataRd && $past(dataRd) && !$past(wrEn)) |-> $stable(rdData));

  // R9: an idle bus returns zero
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rdEn |-> (rdData == 32'h0));

endmodule

bind crc_word_engine crc_word_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .rdData(rdData)
);

// File: tb/crc_word_engine_tb.sv
module crc_word_engine_tb;

  localparam logic [4:0] A_DATA = 5'h00;
  localparam logic [4:0] A_CTRL = 5'h08;
  localparam logic [4:0] A_SEED = 5'h10;
  localparam logic [4:0] A_POLY = 5'h14;
  localparam logic [31:0] P32  = 32'h04C1_1DB7;
  localparam logic [31:0] P32C = 32'h1EDC_6F41;

  // {inMode[1:0], outRev, dataWord}
  localparam int NVEC = 8;
  localparam logic [34:0] VEC [NVEC] = '{
    {2'b00, 1'b0, 32'h1234_5678},
    {2'b11, 1'b0, 32'hDEAD_BEEF},
    {2'b01, 1'b0, 32'h0000_00FF},
    {2'b10, 1'b1, 32'hA5A5_A5A5},
    {2'b11, 1'b1, 32'hFFFF_FFFF},
    {2'b00, 1'b1, 32'h8000_0000},
    {2'b01, 1'b1, 32'h0000_0001},
    {2'b11, 1'b0, 32'h0000_0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  crc_word_engine u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData)
  );

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  function automatic logic [31:0] revLanes(input logic [31:0] v);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 8; i++) r[b*8+i] = v[b*8+7-i];
    return r;
  endfunction

  // plain MSB-first long division step over one word
  function automatic logic [31:0] modelFold(input logic [31:0] c, input logic [31:0] w,
                                            input logic [1:0] m, input logic [31:0] p);
    logic [31:0] d;
    logic top;
    d = (m == 2'b00) ? w : (m == 2'b11) ? rev32(w) : revLanes(w);
    for (int i = 31; i >= 0; i--) begin
      top = c[31];
      c = c << 1;
      if (top != d[i]) c = c ^ p;
    end
    return c;
  endfunction

  // reflected LSB-first form with a reversed generator
  function automatic logic [31:0] modelRefl(input logic [31:0] r, input logic [31:0] w,
                                            input logic [31:0] rp);
    logic low;
    for (int i = 0; i < 32; i++) begin
      low = r[0] ^ w[i];
      r = r >> 1;
      if (low) r = r ^ rp;
    end
    return r;
  endfunction

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; rdEn = 1'b0; addr = a; wrData = d;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b1; addr = a; wrData = '0;
    #2 v = rdData;
    rdEn = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, got, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2, expC, r;
    logic [1:0] m;
    logic o;
    logic [31:0] ctlWord;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_SEED, v); chk("R1 seed", v, 32'hFFFF_FFFF);
    rd(A_POLY, v); chk("R1 poly", v, P32);
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd(A_DATA, v); chk("R1 data", v, 32'hFFFF_FFFF);

    // R5 R6 table walk: reload under each mode, fold one word
    for (int k = 0; k < NVEC; k++) begin
      m = VEC[k][34:33];
      o = VEC[k][32];
      ctlWord = 32'(m) << 6 | 32'(o) << 5 | 32'h1;
      wr(A_CTRL, ctlWord);
      wr(A_DATA, VEC[k][31:0]);
      expC = modelFold(32'hFFFF_FFFF, VEC[k][31:0], m, P32);
      if (o) expC = rev32(expC);
      rd(A_DATA, v);
      chk($sformatf("R5/R6 vector %0d", k), v, expC);
      rd(A_CTRL, v);
      chk($sformatf("R4 ctrl readback %0d", k), v, ctlWord & 32'hE0);
    end

    // R2 back-to-back writes, R3 repeated reads and continuation
    wr(A_CTRL, 32'h1);
    wr(A_DATA, 32'h0102_0304);
    wr(A_DATA, 32'hCAFE_F00D);
    wr(A_DATA, 32'h7777_0000);
    expC = modelFold(32'hFFFF_FFFF, 32'h0102_0304, 2'b00, P32);
    expC = modelFold(expC, 32'hCAFE_F00D, 2'b00, P32);
    expC = modelFold(expC, 32'h7777_0000, 2'b00, P32);
    rd(A_DATA, v);  chk("R2 back-to-back", v, expC);
    rd(A_DATA, v2); chk("R3 second read", v2, expC);
    wr(A_DATA, 32'h0000_0042);
    expC = modelFold(expC, 32'h0000_0042, 2'b00, P32);
    rd(A_DATA, v);  chk("R3 continue after read", v, expC);

    // R8 seed and polynomial writes leave the running value
    wr(A_SEED, 32'h1357_9BDF);
    wr(A_POLY, P32C);
    rd(A_DATA, v); chk("R8 running unchanged", v, expC);
    rd(A_SEED, v); chk("R8 seed readback", v, 32'h1357_9BDF);
    // R4 reload takes the new seed
    wr(A_CTRL, 32'h1);
    rd(A_DATA, v); chk("R4 reload from seed", v, 32'h1357_9BDF);

    // R7 reflected CRC-32C then CRC-32, two words each
    wr(A_SEED, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'hE1);
    wr(A_DATA, 32'h3433_3231);
    wr(A_DATA, 32'h3837_3635);
    r = modelRefl(32'hFFFF_FFFF, 32'h3433_3231, 32'h82F6_3B78);
    r = modelRefl(r, 32'h3837_3635, 32'h82F6_3B78);
    rd(A_DATA, v); chk("R7 reflected crc32c", v, r);
    wr(A_POLY, P32);
    wr(A_CTRL, 32'hE1);
    wr(A_DATA, 32'h3433_3231);
    wr(A_DATA, 32'h3837_3635);
    r = modelRefl(32'hFFFF_FFFF, 32'h3433_3231, 32'hEDB8_8320);
    r = modelRefl(r, 32'h3837_3635, 32'hEDB8_8320);
    rd(A_DATA, v); chk("R7 reflected crc32", v, r);

    // R9 holes, unused bits and ignored low address bits
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R9 ctrl unused bits", v, 32'hE0);
    wr(5'h0C, 32'hDEAD_0000);
    wr(5'h04, 32'h0BAD_0BAD);
    rd(5'h04, v); chk("R9 hole reads zero", v, 32'h0);
    rd(A_SEED, v); chk("R9 seed untouched", v, 32'hFFFF_FFFF);
    rd(A_POLY, v); chk("R9 poly untouched", v, P32);
    rd(5'h16, v); chk("R9 low addr bits ignored", v, P32);

    // R10 zero seed, zero data stays zero
    wr(A_SEED, 32'h0);
    wr(A_CTRL, 32'h1);
    wr(A_DATA, 32'h0);
    rd(A_DATA, v); chk("R10 no final xor", v, 32'h0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule